// File: doc/BRIEF.md
# Macro Processor Arithmetic and Bitfield Unit

This unit is the execute stage of a small 32-bit macro processor. For each issued instruction it takes the 32-bit instruction word and two operand values already read from the register file, works out the operation class and any sub-operation, and returns a 32-bit result one clock later, marked by a result strobe. It covers four kinds of work:

- register-to-register arithmetic and logic;
- addition of a signed immediate;
- three bitfield forms, whose source position, width and destination position are all encoded in the instruction;
- a read-immediate form that presents an address to an external register space and returns the data read there.

A single carry flag lives inside the unit and persists from one instruction to the next, so multi-word add and subtract sequences can be chained. Fetch, branching, the register file and dispatch of the result are handled by the surrounding processor. Opcode values that the unit does not define raise an illegal flag in place of the result strobe.

Top module: `macro_alu`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises, `res_valid`, `illegal`, `carry` and `result` are all zero.
- R2: An instruction presented with `op_valid` high produces its result on `result`, with `res_valid` high for exactly one cycle, at the next rising clock edge. With `op_valid` low, `res_valid` and `illegal` stay low and `result` and `carry` hold their values.
- R3: Class is `instr[2:0]`. Class 0 is register-to-register, with the sub-operation in `instr[21:17]`. Sub-operation 0 gives A+B. Sub-operation 1 gives A+B+carry. For both, `carry` becomes bit 32 of the unsigned 33-bit sum.
- R4: Register sub-operation 2 gives A−B. Sub-operation 3 gives A−B−1 when `carry` is clear and A−B when it is set. For both, `carry` becomes 1 exactly when the unsigned subtraction needs no borrow.
- R5: Register sub-operations 8 to 12 give, in turn: A XOR B, A OR B, A AND B, A AND NOT B, and NOT(A AND B).
- R6: Class 1 gives A plus the immediate. The immediate is `instr[31:14]`, sign-extended from bit 17.
- R7: Class 2 is bitfield replace. The fields are source bit `instr[21:17]`, size `instr[26:22]` and destination bit `instr[31:27]`, with mask (1<<size)−1. The field is (B >> source) AND mask. It is written into A at the destination bit, and every other bit of A is kept. Field bits shifted above bit 31 are dropped.
- R8: Class 3 gives ((B >> A) AND mask) << destination bit. Only A[4:0] is used as the shift amount.
- R9: Class 4 gives ((B >> source bit) AND mask) << A. Only A[4:0] is used as the shift amount. All right shifts in the unit are logical.
- R10: Class 5 drives `rd_en` high in the same cycle, with `rd_addr` = A + sign-extended immediate. The `rd_data` sampled at that clock edge becomes the result.
- R11: Only register sub-operations 0 to 3 change `carry`. Every other operation leaves it unchanged.
- R12: Register sub-operations 4–7 and 13–31, and classes 6 and 7, pulse `illegal` for one cycle in place of `res_valid`. They leave `result` and `carry` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Instruction and operands are valid this cycle |
| instr | input | 32 | Instruction word |
| opa | input | DATA_W | Operand A |
| opb | input | DATA_W | Operand B |
| rd_en | output | 1 | External register read request (read-immediate class) |
| rd_addr | output | DATA_W | External register read address |
| rd_data | input | DATA_W | Data returned for the read request, same cycle |
| res_valid | output | 1 | Result strobe |
| result | output | DATA_W | Registered result |
| illegal | output | 1 | Undefined operation strobe |
| carry | output | 1 | Persistent carry flag |

## Verification
The following properties are checked by assertions on every cycle:

- `res_valid` and `illegal` never rise together.
- Idle cycles hold `result` and `carry` steady.
- Any operation other than the four add and subtract forms leaves `carry` alone.
- Classes 6 and 7 raise `illegal`.
- A plain add yields the full 33-bit sum across `carry` and `result`.
- Add-immediate and read-immediate return the expected values.

Only the bench scenarios exercise the following:

- the chained carry and borrow sequences;
- the exact placement of bitfields at the mask and shift extremes, including zero-size fields and fields clipped at bit 31;
- the use of only the low five bits of A as a shift amount;
- the undefined sub-operation codes.

// File: rtl/macro_alu_pkg.sv
package macro_alu_pkg;

    localparam int INSTR_W  = 32;
    localparam int CLS_W    = 3;
    localparam int FLD_W    = 5;
    localparam int SUB_LSB  = 17;
    localparam int SIZE_LSB = 22;
    localparam int DST_LSB  = 27;
    localparam int IMM_LSB  = 14;
    localparam int IMM_W    = INSTR_W - IMM_LSB;

    typedef enum logic [CLS_W-1:0] {
        CLS_REG     = 3'd0,
        CLS_ADDI    = 3'd1,
        CLS_BF_REP  = 3'd2,
        CLS_BFX_IMM = 3'd3,
        CLS_BFX_REG = 3'd4,
        CLS_RD_IMM  = 3'd5,
        CLS_RSV     = 3'd6,
        CLS_FLOW    = 3'd7
    } op_class_e;

    localparam logic [FLD_W-1:0] SUB_ADD  = 5'd0;
    localparam logic [FLD_W-1:0] SUB_ADC  = 5'd1;
    localparam logic [FLD_W-1:0] SUB_SUB  = 5'd2;
    localparam logic [FLD_W-1:0] SUB_SBB  = 5'd3;
    localparam logic [FLD_W-1:0] SUB_XOR  = 5'd8;
    localparam logic [FLD_W-1:0] SUB_OR   = 5'd9;
    localparam logic [FLD_W-1:0] SUB_AND  = 5'd10;
    localparam logic [FLD_W-1:0] SUB_ANDN = 5'd11;
    localparam logic [FLD_W-1:0] SUB_NAND = 5'd12;

    typedef struct packed {
        op_class_e        cls;
        logic [FLD_W-1:0] sub;
        logic [FLD_W-1:0] src;
        logic [FLD_W-1:0] size;
        logic [FLD_W-1:0] dst;
        logic [IMM_W-1:0] imm;
    } fields_t;

endpackage

// File: rtl/macro_alu_decode.sv
module macro_alu_decode
    import macro_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [INSTR_W-1:0] instr,
    output fields_t            fld,
    output logic [DATA_W-1:0]  imm_sx
);

    always_comb begin
        fld.cls  = op_class_e'(instr[CLS_W-1:0]);
        fld.sub  = instr[SUB_LSB  +: FLD_W];
        fld.src  = instr[SUB_LSB  +: FLD_W];
        fld.size = instr[SIZE_LSB +: FLD_W];
        fld.dst  = instr[DST_LSB  +: FLD_W];
        fld.imm  = instr[IMM_LSB  +: IMM_W];
        imm_sx   = {{(DATA_W-IMM_W){fld.imm[IMM_W-1]}}, fld.imm};
    end

endmodule

// File: rtl/macro_alu_rr.sv
module macro_alu_rr
    import macro_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              carry_in,
    input  logic [FLD_W-1:0]  sub,
    output logic [DATA_W-1:0] res,
    output logic              carry_out,
    output logic              carry_wr,
    output logic              legal
);

    localparam int WIDE_W = DATA_W + 1;

    logic [WIDE_W-1:0] wide;
    logic [WIDE_W-1:0] cin_w;
    logic [WIDE_W-1:0] bin_w;

    assign cin_w = {{DATA_W{1'b0}}, carry_in};
    assign bin_w = {{DATA_W{1'b0}}, ~carry_in};

    always_comb begin
        wide      = '0;
        res       = '0;
        carry_out = 1'b0;
        carry_wr  = 1'b0;
        legal     = 1'b1;
        case (sub)
            SUB_ADD: begin
                wide      = {1'b0, a} + {1'b0, b};
                carry_out = wide[DATA_W];
                carry_wr  = 1'b1;
            end
            SUB_ADC: begin
                wide      = {1'b0, a} + {1'b0, b} + cin_w;
                carry_out = wide[DATA_W];
                carry_wr  = 1'b1;
            end
            SUB_SUB: begin
                wide      = {1'b0, a} - {1'b0, b};
                carry_out = ~wide[DATA_W];
                carry_wr  = 1'b1;
            end
            SUB_SBB: begin
                wide      = {1'b0, a} - {1'b0, b} - bin_w;
                carry_out = ~wide[DATA_W];
                carry_wr  = 1'b1;
            end
            SUB_XOR:  wide = {1'b0, a ^ b};
            SUB_OR:   wide = {1'b0, a | b};
            SUB_AND:  wide = {1'b0, a & b};
            SUB_ANDN: wide = {1'b0, a & ~b};
            SUB_NAND: wide = {1'b0, ~(a & b)};
            default:  legal = 1'b0;
        endcase
        res = wide[DATA_W-1:0];
    end

endmodule

// File: rtl/macro_alu_bf.sv
module macro_alu_bf
    import macro_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  op_class_e         cls,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [FLD_W-1:0]  src,
    input  logic [FLD_W-1:0]  size,
    input  logic [FLD_W-1:0]  dst,
    output logic [DATA_W-1:0] res
);

    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0] mask;
    logic [SH_W-1:0]   a_sh;
    logic [SH_W-1:0]   src_sh;
    logic [SH_W-1:0]   dst_sh;
    logic [DATA_W-1:0] fld_src;
    logic [DATA_W-1:0] fld_dyn;

    genvar gi;
    generate
        for (gi = 0; gi < DATA_W; gi++) begin : g_mask
            assign mask[gi] = ((SH_W + 1)'(gi) < (SH_W + 1)'(size));
        end
    endgenerate

    assign a_sh    = a[SH_W-1:0];
    assign src_sh  = src[SH_W-1:0];
    assign dst_sh  = dst[SH_W-1:0];
    assign fld_src = (b >> src_sh) & mask;
    assign fld_dyn = (b >> a_sh) & mask;

    always_comb begin
        case (cls)
            CLS_BF_REP:  res = (a & ~(mask << dst_sh)) | (fld_src << dst_sh);
            CLS_BFX_IMM: res = fld_dyn << dst_sh;
            CLS_BFX_REG: res = fld_src << a_sh;
            default:     res = '0;
        endcase
    end

endmodule

// File: rtl/macro_alu.sv
module macro_alu
    import macro_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               op_valid,
    input  logic [31:0]        instr,
    input  logic [DATA_W-1:0]  opa,
    input  logic [DATA_W-1:0]  opb,
    output logic               rd_en,
    output logic [DATA_W-1:0]  rd_addr,
    input  logic [DATA_W-1:0]  rd_data,
    output logic               res_valid,
    output logic [DATA_W-1:0]  result,
    output logic               illegal,
    output logic               carry
);

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              valid;
        logic              illegal;
        logic              carry;
    } alu_state_t;

    alu_state_t st_d, st_q;

    fields_t           fld;
    logic [DATA_W-1:0] imm_sx;
    logic [DATA_W-1:0] rr_res;
    logic              rr_carry;
    logic              rr_cwr;
    logic              rr_legal;
    logic [DATA_W-1:0] bf_res;

    macro_alu_decode #(.DATA_W(DATA_W)) u_dec (
        .instr  (instr),
        .fld    (fld),
        .imm_sx (imm_sx)
    );

    macro_alu_rr #(.DATA_W(DATA_W)) u_rr (
        .a         (opa),
        .b         (opb),
        .carry_in  (st_q.carry),
        .sub       (fld.sub),
        .res       (rr_res),
        .carry_out (rr_carry),
        .carry_wr  (rr_cwr),
        .legal     (rr_legal)
    );

    macro_alu_bf #(.DATA_W(DATA_W)) u_bf (
        .cls  (fld.cls),
        .a    (opa),
        .b    (opb),
        .src  (fld.src),
        .size (fld.size),
        .dst  (fld.dst),
        .res  (bf_res)
    );

    assign rd_en   = op_valid && (fld.cls == CLS_RD_IMM);
    assign rd_addr = opa + imm_sx;

    always_comb begin
        st_d         = st_q;
        st_d.valid   = 1'b0;
        st_d.illegal = 1'b0;
        if (op_valid) begin
            case (fld.cls)
                CLS_REG: begin
                    if (rr_legal) begin
                        st_d.result = rr_res;
                        st_d.valid  = 1'b1;
                        if (rr_cwr) begin
                            st_d.carry = rr_carry;
                        end
                    end else begin
                        st_d.illegal = 1'b1;
                    end
                end
                CLS_ADDI: begin
                    st_d.result = opa + imm_sx;
                    st_d.valid  = 1'b1;
                end
                CLS_BF_REP, CLS_BFX_IMM, CLS_BFX_REG: begin
                    st_d.result = bf_res;
                    st_d.valid  = 1'b1;
                end
                CLS_RD_IMM: begin
                    st_d.result = rd_data;
                    st_d.valid  = 1'b1;
                end
                default: st_d.illegal = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_valid = st_q.valid;
    assign result    = st_q.result;
    assign illegal   = st_q.illegal;
    assign carry     = st_q.carry;

endmodule

// File: rtl/macro_alu_chk.sv
module macro_alu_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic [31:0]       instr,
    input logic [DATA_W-1:0] opa,
    input logic [DATA_W-1:0] opb,
    input logic [DATA_W-1:0] rd_data,
    input logic              res_valid,
    input logic [DATA_W-1:0] result,
    input logic              illegal,
    input logic              carry
);

    p_strobe_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && illegal));

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> (!res_valid && !illegal && $stable(result) && $stable(carry)));

    p_carry_keep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !(instr[2:0] == 3'd0 && instr[21:17] < 5'd4)) |=> $stable(carry));

    p_bad_class_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && instr[2:0] >= 3'd6) |=> (illegal && !res_valid));

    p_read_data_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && instr[2:0] == 3'd5) |=> (res_valid && result == $past(rd_data)));

    p_add_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && instr[2:0] == 3'd0 && instr[21:17] == 5'd0)
        |=> ({carry, result} == ({1'b0, $past(opa)} + {1'b0, $past(opb)})));

    p_addi_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && instr[2:0] == 3'd1)
        |=> (result == $past(opa) + {{(DATA_W-18){$past(instr[31])}}, $past(instr[31:14])}));

endmodule

bind macro_alu macro_alu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_valid  (op_valid),
    .instr     (instr),
    .opa       (opa),
    .opb       (opb),
    .rd_data   (rd_data),
    .res_valid (res_valid),
    .result    (result),
    .illegal   (illegal),
    .carry     (carry)
);

// File: tb/tb_macro_alu.sv
`timescale 1ns/1ps
module tb_macro_alu;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [31:0] rd_data = '0;
    logic        rd_en;
    logic [31:0] rd_addr;
    logic        res_valid;
    logic [31:0] result;
    logic        illegal;
    logic        carry;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    macro_alu #(.DATA_W(32)) dut (
        .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .instr (instr),
        .opa (opa), .opb (opb), .rd_en (rd_en), .rd_addr (rd_addr),
        .rd_data (rd_data), .res_valid (res_valid), .result (result),
        .illegal (illegal), .carry (carry)
    );

    function automatic logic [31:0] f_rr(input logic [4:0] s);
        return {10'd0, s, 14'd0, 3'd0};
    endfunction

    function automatic logic [31:0] f_imm(input logic [2:0] c, input logic [17:0] im);
        return {im, 11'd0, c};
    endfunction

    function automatic logic [31:0] f_bf(input logic [2:0] c, input logic [4:0] src,
                                         input logic [4:0] sz, input logic [4:0] dst);
        return {dst, sz, src, 14'd0, c};
    endfunction

    // {instr, A, B, expected result, expected carry after}
    localparam int NV = 21;
    localparam logic [128:0] VEC [NV] = '{
        {f_rr(5'd0),  32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000, 1'b1},
        {f_rr(5'd1),  32'h0000_0005, 32'h0000_0006, 32'h0000_000C, 1'b0},
        {f_rr(5'd0),  32'h8000_0000, 32'h8000_0000, 32'h0000_0000, 1'b1},
        {f_rr(5'd8),  32'hF0F0_F0F0, 32'hFF00_FF00, 32'h0FF0_0FF0, 1'b1},
        {f_rr(5'd2),  32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE, 1'b0},
        {f_rr(5'd3),  32'h0000_000A, 32'h0000_0003, 32'h0000_0006, 1'b1},
        {f_rr(5'd2),  32'h0000_0007, 32'h0000_0007, 32'h0000_0000, 1'b1},
        {f_rr(5'd3),  32'h0000_0005, 32'h0000_0002, 32'h0000_0003, 1'b1},
        {f_rr(5'd9),  32'h00FF_0000, 32'h0000_FF00, 32'h00FF_FF00, 1'b1},
        {f_rr(5'd10), 32'h1234_5678, 32'h0F0F_0F0F, 32'h0204_0608, 1'b1},
        {f_rr(5'd11), 32'hFFFF_0000, 32'h0FF0_0000, 32'hF00F_0000, 1'b1},
        {f_rr(5'd12), 32'hFFFF_0000, 32'h00FF_FF00, 32'hFF00_FFFF, 1'b1},
        {f_imm(3'd1, 18'h3FFFF), 32'd100, 32'h0, 32'd99, 1'b1},
        {f_imm(3'd1, 18'h1FFFF), 32'h0000_0010, 32'h0, 32'h0002_000F, 1'b1},
        {f_bf(3'd2, 5'd4, 5'd4, 5'd8),  32'hFFFF_FFFF, 32'h0000_00AB, 32'hFFFF_FAFF, 1'b1},
        {f_bf(3'd2, 5'd0, 5'd0, 5'd0),  32'h1234_5678, 32'hFFFF_FFFF, 32'h1234_5678, 1'b1},
        {f_bf(3'd2, 5'd0, 5'd8, 5'd28), 32'h0000_0000, 32'h0000_00FF, 32'hF000_0000, 1'b1},
        {f_bf(3'd3, 5'd0, 5'd8, 5'd4),  32'd8,  32'h0000_AB00, 32'h0000_0AB0, 1'b1},
        {f_bf(3'd3, 5'd0, 5'd8, 5'd4),  32'd40, 32'h0000_AB00, 32'h0000_0AB0, 1'b1},
        {f_bf(3'd4, 5'd16, 5'd4, 5'd0), 32'd28, 32'h000F_0000, 32'hF000_0000, 1'b1},
        {f_bf(3'd4, 5'd0, 5'd31, 5'd0), 32'd1,  32'hFFFF_FFFF, 32'hFFFF_FFFE, 1'b1}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic issue(input logic [31:0] i, input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] rd);
        @(negedge clk);
        op_valid = 1'b1;
        instr    = i;
        opa      = a;
        opb      = b;
        rd_data  = rd;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [128:0] v;
        logic [31:0]  held;
        string        tag;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1", "res_valid", {31'd0, res_valid}, 32'd0);
        chk("R1", "illegal",   {31'd0, illegal},   32'd0);
        chk("R1", "carry",     {31'd0, carry},     32'd0);
        chk("R1", "result",    result,             32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "result after release", result, 32'd0);

        // Table walk: R3..R9, carry tracked for R11
        for (int k = 0; k < NV; k++) begin
            v = VEC[k];
            issue(v[128:97], v[96:65], v[64:33], 32'd0);
            if (v[99:97] == 3'd0)
                tag = (v[118:114] < 5'd2) ? "R3" : (v[118:114] < 5'd4) ? "R4" : "R5";
            else if (v[99:97] == 3'd1) tag = "R6";
            else if (v[99:97] == 3'd2) tag = "R7";
            else if (v[99:97] == 3'd3) tag = "R8";
            else tag = "R9";
            chk(tag, $sformatf("vec %0d result", k), result, v[32:1]);
            chk("R2", $sformatf("vec %0d strobe", k), {31'd0, res_valid}, 32'd1);
            chk((v[99:97] == 3'd0 && v[118:114] < 5'd4) ? tag : "R11",
                $sformatf("vec %0d carry", k), {31'd0, carry}, {31'd0, v[0]});
        end

        // R2 idle holds
        held = result;
        repeat (2) @(negedge clk);
        chk("R2", "idle strobe", {31'd0, res_valid}, 32'd0);
        chk("R2", "idle result", result, held);

        // R10 read immediate, positive and negative offsets
        @(negedge clk);
        op_valid = 1'b1; instr = f_imm(3'd5, 18'd4); opa = 32'h100; rd_data = 32'hCAFE_0001;
        #1;
        chk("R10", "rd_en", {31'd0, rd_en}, 32'd1);
        chk("R10", "rd_addr", rd_addr, 32'h104);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R10", "read result", result, 32'hCAFE_0001);
        @(negedge clk);
        op_valid = 1'b1; instr = f_imm(3'd5, 18'h3FFF8); opa = 32'h100; rd_data = 32'h0BAD_F00D;
        #1;
        chk("R10", "rd_addr neg", rd_addr, 32'h0F8);
        @(negedge clk);
        op_valid = 1'b0;
        #1;
        chk("R10", "rd_en idle", {31'd0, rd_en}, 32'd0);
        chk("R10", "read result neg", result, 32'h0BAD_F00D);
        chk("R11", "carry after read", {31'd0, carry}, 32'd1);

        // R12 undefined sub-op keeps result and carry
        issue(f_rr(5'd0), 32'd1, 32'd1, 32'd0);
        chk("R3", "add small carry clear", {31'd0, carry}, 32'd0);
        held = result;
        issue(f_rr(5'd4), 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0);
        chk("R12", "illegal sub4 flag", {31'd0, illegal}, 32'd1);
        chk("R12", "illegal sub4 strobe", {31'd0, res_valid}, 32'd0);
        chk("R12", "illegal sub4 result", result, held);
        chk("R12", "illegal sub4 carry", {31'd0, carry}, 32'd0);
        issue(f_rr(5'd13), 32'h5, 32'h5, 32'd0);
        chk("R12", "illegal sub13 flag", {31'd0, illegal}, 32'd1);
        issue(32'h0000_0006, 32'h5, 32'h5, 32'd0);
        chk("R12", "class6 flag", {31'd0, illegal}, 32'd1);
        issue(32'h0000_0007, 32'h5, 32'h5, 32'd0);
        chk("R12", "class7 flag", {31'd0, illegal}, 32'd1);
        chk("R12", "class7 result", result, held);
        @(negedge clk);
        chk("R12", "illegal one cycle", {31'd0, illegal}, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule